// File: doc/BRIEF.md
# Dual-Channel Disk Port Address Router

This block sits between a host I/O request path and four disk drives on two channels. Five windows can each be moved through a small base-load port: a command window and a control window for each channel, and one bus-master window. Each request address is compared against all five windows. A hit produces a registered decode record: the region type, the channel, the offset inside the window and the index of the drive that the access targets.

The router keeps one drive-select bit per channel, so the two drives on a channel share the same window. Writing the select register in a command window updates that bit. A master enable turns all request handling on or off. The router checks the width of each access against the register it hits. It turns command-window data-port accesses into 16-bit drive strobes, and a 32-bit access becomes two strobes. Read data from the drive comes back on a single read-return port. Bus-master hits are decoded only. Their register contents belong to another block.

Top module: `ata_port_router`

## Requirements
- R1: After a synchronous reset, `dec_valid`, `err`, `drv_valid` and `rd_valid` are low, `rd_data` is zero, both drive-select bits are 0 and all five window bases are 0.
- R2: An accepted request hits the window that holds its address. `dec_region` gives the window type (1 = command, 2 = control, 3 = bus-master) and `dec_off` is the request address minus that window's base. Windows are sized by the CMD_SZ, CTL_SZ and BM_SZ parameters.
- R3: When windows overlap, the first hit wins, in this order: primary command, primary control, secondary command, secondary control, bus-master. These are `cfg_idx` values 0 to 4. Loads to any other index are ignored.
- R4: For a command or control hit, the channel is the window's channel. For a bus-master hit, the channel is primary (0) when the offset is below BM_SPLIT and secondary (1) otherwise.
- R5: The drive index is channel×2 plus that channel's select bit. A byte write to offset SEL_OFF of a command window sets the channel's select bit to bit DEV_BIT of the write data. The same write is forwarded to the newly selected drive.
- R6: While `io_en` is low, requests produce no decode, no error, no drive strobe and no read data, and they leave the select bits unchanged.
- R7: `req_size` encodes 0 = 8-bit, 1 = 16-bit, 2 = 32-bit and 3 = illegal. Command-window offset 0 (the data port) takes 16-bit or 32-bit accesses only. All other command and control offsets take 8-bit accesses only. The bus-master window takes 8, 16 or 32 bits.
- R8: A 32-bit data-port access produces two consecutive drive strobes. The first has `drv_hi` = 0 and carries write data bits 15:0. The second has `drv_hi` = 1 and carries bits 31:16. Drive index and offset are the same on both. A 32-bit read returns {high half, low half} one cycle after the second strobe.
- R9: A base load of zero leaves that window's base unchanged. A non-zero load takes effect for the next request.
- R10: An accepted request that hits no window, or that has an illegal width, pulses `err` for one cycle. It produces no decode record and no drive strobe.
- R11: When `drv_present` is low for the target drive, a read returns all-ones on `rd_valid` one cycle after the decode, and a write produces no strobe.
- R12: Decode, error and the first drive strobe appear one cycle after the request. A single-strobe read returns one cycle after its strobe: an 8-bit read is zero-extended from drive bits 7:0, and a 16-bit read is zero-extended from bits 15:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_en | input | 1 | Master enable for request handling |
| cfg_we | input | 1 | Base-load strobe |
| cfg_idx | input | 3 | Window selected for the base load (0..4) |
| cfg_base | input | ADDR_W | New base address; zero is ignored |
| req_valid | input | 1 | Request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Request address |
| req_size | input | 2 | Access width code |
| req_wdata | input | 32 | Write data |
| drv_present | input | 4 | One bit per drive: drive attached |
| drv_rdata | input | 16 | Drive read data, valid in the strobe cycle |
| dec_valid | output | 1 | Decode record valid |
| dec_region | output | 2 | Region type of the hit |
| dec_chan | output | 1 | Channel of the hit |
| dec_off | output | OFF_W | Offset inside the window |
| dec_drive | output | 2 | Target drive index |
| err | output | 1 | Miss or illegal-width pulse |
| drv_valid | output | 1 | Drive access strobe |
| drv_write | output | 1 | Strobe is a write |
| drv_hi | output | 1 | Strobe carries the upper half of a 32-bit access |
| drv_idx | output | 2 | Drive addressed by the strobe |
| drv_region | output | 2 | Command or control region of the strobe |
| drv_off | output | OFF_W | Register offset of the strobe |
| drv_wdata | output | 16 | Write data of the strobe |
| rd_valid | output | 1 | Read data return |
| rd_data | output | 32 | Returned read data |

## Verification
The assertions assume three things about the requester and the drives. No request follows a 32-bit data-port access in the very next cycle. `drv_present` does not change between a request and its strobes. `drv_rdata` answers in the same cycle as the strobe. The bench meets all three by design. It spaces every request three cycles apart, changes presence and the enable only between requests, and computes drive read data combinationally from the strobe's index, region, offset and half. The random mix still reaches misses, illegal widths, absent drives and both channels of the bus-master window.

// File: rtl/ata_route_pkg.sv
`timescale 1ns/1ps
package ata_route_pkg;
  typedef enum logic [1:0] {RG_NONE = 2'd0, RG_CMD = 2'd1, RG_CTL = 2'd2, RG_BM = 2'd3} region_e;
  typedef enum logic [1:0] {SZ_B = 2'd0, SZ_H = 2'd1, SZ_W = 2'd2, SZ_BAD = 2'd3} size_e;

  localparam int NWIN = 5;

  // window index order is the match priority: 0 pri cmd, 1 pri ctl, 2 sec cmd, 3 sec ctl, 4 bus-master
  function automatic region_e win_region(input int w);
    if (w == NWIN - 1) return RG_BM;
    return (w % 2 == 0) ? RG_CMD : RG_CTL;
  endfunction
endpackage

// File: rtl/ata_win_bank.sv
`timescale 1ns/1ps
module ata_win_bank
  import ata_route_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int OFF_W  = 4,
  parameter int CMD_SZ = 8,
  parameter int CTL_SZ = 4,
  parameter int BM_SZ  = 16
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           cfg_we,
  input  logic [2:0]                     cfg_idx,
  input  logic [ADDR_W-1:0]              cfg_base,
  input  logic [ADDR_W-1:0]              addr,
  output logic [NWIN-1:0]                hit,
  output logic [NWIN-1:0][OFF_W-1:0]     offs
);
  for (genvar w = 0; w < NWIN; w++) begin : g_win
    localparam int SZ = (w == NWIN - 1) ? BM_SZ : ((w % 2 == 0) ? CMD_SZ : CTL_SZ);
    logic [ADDR_W-1:0] base_q;

    always_ff @(posedge clk) begin
      if (rst)
        base_q <= '0;
      else if (cfg_we && cfg_idx == 3'(w) && cfg_base != '0)
        base_q <= cfg_base;
    end

    assign hit[w]  = ({1'b0, addr} >= {1'b0, base_q}) &&
                     ({1'b0, addr} <  ({1'b0, base_q} + (ADDR_W+1)'(SZ)));
    assign offs[w] = OFF_W'(addr - base_q);
  end
endmodule

// File: rtl/ata_win_pick.sv
`timescale 1ns/1ps
module ata_win_pick
  import ata_route_pkg::*;
#(
  parameter int OFF_W    = 4,
  parameter int BM_SPLIT = 8
) (
  input  logic [NWIN-1:0]            hit,
  input  logic [NWIN-1:0][OFF_W-1:0] offs,
  output logic                       any,
  output logic [1:0]                 region,
  output logic                       chan,
  output logic [OFF_W-1:0]           off
);
  always_comb begin
    any    = 1'b0;
    region = RG_NONE;
    chan   = 1'b0;
    off    = '0;
    // walk from lowest priority up so the earliest window overrides
    for (int w = NWIN - 1; w >= 0; w--) begin
      if (hit[w]) begin
        any    = 1'b1;
        region = win_region(w);
        off    = offs[w];
        if (w == NWIN - 1) chan = (offs[w] >= OFF_W'(BM_SPLIT));
        else               chan = (w >= 2);
      end
    end
  end
endmodule

// File: rtl/ata_port_router.sv
`timescale 1ns/1ps
module ata_port_router
  import ata_route_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int CMD_SZ   = 8,
  parameter int CTL_SZ   = 4,
  parameter int BM_SZ    = 16,
  parameter int BM_SPLIT = 8,
  parameter int SEL_OFF  = 6,
  parameter int DEV_BIT  = 4,
  parameter int DAT_OFF  = 0,
  localparam int MAX_SZ  = (BM_SZ > CMD_SZ) ? ((BM_SZ > CTL_SZ) ? BM_SZ : CTL_SZ)
                                            : ((CMD_SZ > CTL_SZ) ? CMD_SZ : CTL_SZ),
  localparam int OFF_W   = $clog2(MAX_SZ)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              io_en,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_idx,
  input  logic [ADDR_W-1:0] cfg_base,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  input  logic [31:0]       req_wdata,
  input  logic [3:0]        drv_present,
  input  logic [15:0]       drv_rdata,
  output logic              dec_valid,
  output logic [1:0]        dec_region,
  output logic              dec_chan,
  output logic [OFF_W-1:0]  dec_off,
  output logic [1:0]        dec_drive,
  output logic              err,
  output logic              drv_valid,
  output logic              drv_write,
  output logic              drv_hi,
  output logic [1:0]        drv_idx,
  output logic [1:0]        drv_region,
  output logic [OFF_W-1:0]  drv_off,
  output logic [15:0]       drv_wdata,
  output logic              rd_valid,
  output logic [31:0]       rd_data
);
  logic [NWIN-1:0]            hit;
  logic [NWIN-1:0][OFF_W-1:0] offs;
  logic                       any, chan;
  logic [1:0]                 region;
  logic [OFF_W-1:0]           off;

  ata_win_bank #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .CMD_SZ(CMD_SZ), .CTL_SZ(CTL_SZ), .BM_SZ(BM_SZ))
    u_bank (.clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_base(cfg_base),
            .addr(req_addr), .hit(hit), .offs(offs));

  ata_win_pick #(.OFF_W(OFF_W), .BM_SPLIT(BM_SPLIT))
    u_pick (.hit(hit), .offs(offs), .any(any), .region(region), .chan(chan), .off(off));

  logic [1:0]  sel_q;
  logic        hi_pend_q, miss_q;
  logic [15:0] whi_q, rlo_q;
  logic [1:0]  rsz_q;

  logic width_ok, acc, good, bad, sel_wr, sel_eff, dev, pres;
  logic [1:0] idx;

  always_comb begin
    if (req_size == SZ_BAD)                                   width_ok = 1'b0;
    else if (region == RG_BM)                                 width_ok = 1'b1;
    else if (region == RG_CMD && off == OFF_W'(DAT_OFF))      width_ok = (req_size == SZ_H) || (req_size == SZ_W);
    else                                                      width_ok = (req_size == SZ_B);
  end

  assign acc     = req_valid && io_en && !hi_pend_q;
  assign good    = acc && any && width_ok;
  assign bad     = acc && !(any && width_ok);
  assign sel_wr  = good && req_write && region == RG_CMD && off == OFF_W'(SEL_OFF);
  assign sel_eff = sel_wr ? req_wdata[DEV_BIT] : sel_q[chan];
  assign idx     = {chan, sel_eff};
  assign dev     = good && region != RG_BM;
  assign pres    = drv_present[idx];

  always_ff @(posedge clk) begin
    if (rst) begin
      dec_valid  <= 1'b0;  dec_region <= '0;  dec_chan <= 1'b0;  dec_off <= '0;  dec_drive <= '0;
      err        <= 1'b0;  sel_q      <= '0;
      drv_valid  <= 1'b0;  drv_write  <= 1'b0; drv_hi  <= 1'b0;  drv_idx <= '0;
      drv_region <= '0;    drv_off    <= '0;  drv_wdata <= '0;
      hi_pend_q  <= 1'b0;  miss_q     <= 1'b0; whi_q <= '0; rlo_q <= '0; rsz_q <= '0;
      rd_valid   <= 1'b0;  rd_data    <= '0;
    end else begin
      dec_valid <= good;
      err       <= bad;
      if (good) begin
        dec_region <= region;
        dec_chan   <= chan;
        dec_off    <= off;
        dec_drive  <= idx;
      end
      if (sel_wr) sel_q[chan] <= req_wdata[DEV_BIT];

      drv_valid <= 1'b0;
      hi_pend_q <= 1'b0;
      miss_q    <= 1'b0;
      if (hi_pend_q) begin
        drv_valid <= 1'b1;
        drv_hi    <= 1'b1;
        drv_wdata <= whi_q;
      end else if (dev && pres) begin
        drv_valid  <= 1'b1;
        drv_hi     <= 1'b0;
        drv_write  <= req_write;
        drv_idx    <= idx;
        drv_region <= region;
        drv_off    <= off;
        drv_wdata  <= req_wdata[15:0];
        whi_q      <= req_wdata[31:16];
        rsz_q      <= req_size;
        hi_pend_q  <= (req_size == SZ_W);
      end else if (dev && !req_write) begin
        miss_q <= 1'b1;
      end

      rd_valid <= 1'b0;
      if (miss_q) begin
        rd_valid <= 1'b1;
        rd_data  <= '1;
      end else if (drv_valid && !drv_write) begin
        if (!drv_hi && rsz_q == SZ_W) begin
          rlo_q <= drv_rdata;
        end else begin
          rd_valid <= 1'b1;
          if (drv_hi)              rd_data <= {drv_rdata, rlo_q};
          else if (rsz_q == SZ_B)  rd_data <= {24'h0, drv_rdata[7:0]};
          else                     rd_data <= {16'h0, drv_rdata};
        end
      end
    end
  end
endmodule

// File: rtl/ata_route_chk.sv
`timescale 1ns/1ps
module ata_route_chk #(
  parameter int OFF_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             io_en,
  input logic             err,
  input logic             dec_valid,
  input logic [1:0]       dec_region,
  input logic             dec_chan,
  input logic [1:0]       dec_drive,
  input logic             drv_valid,
  input logic             drv_write,
  input logic             drv_hi,
  input logic [1:0]       drv_idx,
  input logic [OFF_W-1:0] drv_off,
  input logic [3:0]       drv_present,
  input logic             rd_valid
);
  logic [3:0] pres_q;
  always_ff @(posedge clk) pres_q <= drv_present;

  // R10
  err_excl_chk: assert property (@(posedge clk) disable iff (rst)
    err |-> !dec_valid && !drv_valid);

  // R6
  io_gate_chk: assert property (@(posedge clk) disable iff (rst)
    !io_en |=> !dec_valid && !err && !(drv_valid && !drv_hi));

  // R8
  split_order_chk: assert property (@(posedge clk) disable iff (rst)
    (drv_valid && drv_hi) |-> $past(drv_valid && !drv_hi) && $stable(drv_idx) && $stable(drv_off));

  // R8
  split_return_chk: assert property (@(posedge clk) disable iff (rst)
    (drv_valid && drv_hi && !drv_write) |=> rd_valid);

  // R5
  drive_chan_chk: assert property (@(posedge clk) disable iff (rst)
    (dec_valid && dec_region != 2'd3) |-> dec_drive[1] == dec_chan);

  // R11
  present_chk: assert property (@(posedge clk) disable iff (rst)
    (drv_valid && !drv_hi) |-> pres_q[drv_idx]);
endmodule

bind ata_port_router ata_route_chk #(.OFF_W(OFF_W)) u_chk (
  .clk(clk), .rst(rst), .io_en(io_en), .err(err), .dec_valid(dec_valid),
  .dec_region(dec_region), .dec_chan(dec_chan), .dec_drive(dec_drive),
  .drv_valid(drv_valid), .drv_write(drv_write), .drv_hi(drv_hi), .drv_idx(drv_idx),
  .drv_off(drv_off), .drv_present(drv_present), .rd_valid(rd_valid));

// File: tb/ata_port_router_bench.sv
`timescale 1ns/1ps
module ata_port_router_bench;
  logic clk = 1'b0, rst = 1'b1, io_en = 1'b1;
  logic cfg_we = 1'b0; logic [2:0] cfg_idx = '0; logic [15:0] cfg_base = '0;
  logic req_valid = 1'b0, req_write = 1'b0; logic [15:0] req_addr = '0;
  logic [1:0] req_size = '0; logic [31:0] req_wdata = '0;
  logic [3:0] drv_present = 4'hF; logic [15:0] drv_rdata;
  logic dec_valid, dec_chan, err, drv_valid, drv_write, drv_hi, rd_valid;
  logic [1:0] dec_region, dec_drive, drv_idx, drv_region;
  logic [3:0] dec_off, drv_off; logic [15:0] drv_wdata; logic [31:0] rd_data;

  int total = 0, bad = 0;
  int bases[5];
  bit sel[2];
  bit finished = 0;

  always #2.5 clk = ~clk;

  ata_port_router u_ata_port_router (.*);

  function automatic logic [15:0] resp(input logic [1:0] i, input logic [1:0] rg,
                                       input logic h, input logic [3:0] o);
    return {4'hC, i, rg, 3'b000, h, o};
  endfunction
  assign drv_rdata = resp(drv_idx, drv_region, drv_hi, drv_off);

  function automatic int wsize(input int w);
    return (w == 4) ? 16 : ((w % 2 == 0) ? 8 : 4);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic load_base(input int w, input int b);
    cfg_we = 1; cfg_idx = 3'(w); cfg_base = 16'(b);
    @(posedge clk); @(negedge clk);
    cfg_we = 0;
    if (w < 5 && b != 0) bases[w] = b;   // R9: zero load keeps the base
  endtask

  task automatic do_req(input bit wr, input int a, input logic [1:0] sz, input logic [31:0] wd,
                        input string why);
    bit hit = 0, ch = 0, wok, good, bd, selw, se, dev, pr, strobe;
    int rg = 0, of = 0, rdset = 0;
    logic [1:0] ix; logic [31:0] rexp = '0;
    for (int w = 0; w < 5; w++)
      if (!hit && a >= bases[w] && a < bases[w] + wsize(w)) begin
        hit = 1; of = a - bases[w];
        rg = (w == 4) ? 3 : ((w % 2 == 0) ? 1 : 2);
        ch = (w == 4) ? (of >= 8) : (w >= 2);
      end
    if (sz == 3) wok = 0;
    else if (rg == 3) wok = 1;
    else if (rg == 1 && of == 0) wok = (sz == 1 || sz == 2);
    else wok = (sz == 0);
    good = io_en && hit && wok;
    bd = io_en && !good;
    selw = good && wr && rg == 1 && of == 6;
    se = selw ? wd[4] : sel[ch];
    ix = {ch, se};
    dev = good && rg != 3;
    pr = drv_present[ix];
    strobe = dev && pr;
    if (dev && !wr) begin
      if (!pr) begin rdset = 2; rexp = 32'hFFFF_FFFF; end
      else if (sz == 2) begin rdset = 3; rexp = {resp(ix, 2'(rg), 1'b1, 4'(of)), resp(ix, 2'(rg), 1'b0, 4'(of))}; end
      else begin rdset = 2; rexp = (sz == 0) ? {24'h0, resp(ix, 2'(rg), 1'b0, 4'(of)) & 16'h00FF} : {16'h0, resp(ix, 2'(rg), 1'b0, 4'(of))}; end
    end

    req_valid = 1; req_write = wr; req_addr = 16'(a); req_size = sz; req_wdata = wd;
    @(posedge clk); @(negedge clk);
    req_valid = 0;
    chk({"R10 err ", why}, err, bd);
    chk({"R12 dec_valid ", why}, dec_valid, good);
    if (good) begin
      chk({"R2 region ", why}, dec_region, rg);
      chk({"R2 offset ", why}, dec_off, of);
      chk({"R4 channel ", why}, dec_chan, ch);
      chk({"R5 drive ", why}, dec_drive, ix);
    end
    chk({"R11 strobe ", why}, drv_valid, strobe);
    if (strobe) begin
      chk({"R5 drv_idx ", why}, drv_idx, ix);
      chk({"R12 drv_off ", why}, {drv_write, drv_hi, drv_off}, {wr, 1'b0, 4'(of)});
      if (wr) chk({"R8 low half ", why}, drv_wdata, wd[15:0]);
    end
    chk({"R12 rd_valid s1 ", why}, rd_valid, 0);
    if (selw) sel[ch] = wd[4];

    @(negedge clk);
    chk({"R8 second strobe ", why}, drv_valid && drv_hi, strobe && sz == 2);
    if (strobe && sz == 2 && wr) chk({"R8 high half ", why}, drv_wdata, wd[31:16]);
    chk({"R12 rd_valid s2 ", why}, rd_valid, rdset == 2);
    if (rdset == 2) chk({"R11 rd_data ", why}, rd_data, rexp);

    @(negedge clk);
    chk({"R8 rd_valid s3 ", why}, rd_valid, rdset == 3);
    if (rdset == 3) chk({"R8 rd_data ", why}, rd_data, rexp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    for (int w = 0; w < 5; w++) bases[w] = 0;
    sel[0] = 0; sel[1] = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1
    chk("R1 reset outs", {dec_valid, err, drv_valid, rd_valid}, 0);
    chk("R1 reset rd_data", rd_data, 0);

    load_base(0, 'h1F0); load_base(1, 'h3F4); load_base(2, 'h170);
    load_base(3, 'h374); load_base(4, 'hC000);
    load_base(0, 0);      // R9 zero ignored
    load_base(6, 'h0050); // R3 out-of-range index ignored
    do_req(0, 'h1F0, 1, 0, "R9 zero base");
    do_req(0, 'h0050, 0, 0, "R3 bad index");

    // R5 drive select
    do_req(1, 'h1F6, 0, 32'h10, "R5 select pri");
    do_req(0, 'h1F0, 1, 0, "R5 read drive1");
    do_req(1, 'h176, 0, 32'h10, "R5 select sec");
    do_req(0, 'h375, 0, 0, "R5 ctl drive3");
    // R6 disabled select write has no effect
    io_en = 0;
    do_req(1, 'h1F6, 0, 32'h00, "R6 disabled");
    io_en = 1;
    do_req(0, 'h1F7, 0, 0, "R6 sel kept");
    // R7 widths
    do_req(1, 'h1F0, 0, 32'h5, "R7 byte data port");
    do_req(0, 'h1F1, 1, 0, "R7 half reg");
    do_req(0, 'hC002, 3, 0, "R7 size3");
    do_req(0, 'hC004, 2, 0, "R7 bm word");
    // R8 split
    do_req(1, 'h170, 2, 32'hBEEF_1234, "R8 word write");
    do_req(0, 'h1F0, 2, 0, "R8 word read");
    // R4 bm channel split
    do_req(0, 'hC007, 0, 0, "R4 bm pri");
    do_req(0, 'hC008, 0, 0, "R4 bm sec");
    // R10 miss
    do_req(0, 'h0100, 0, 0, "R10 miss");
    // R3 overlap
    load_base(2, 'h1F4);
    do_req(0, 'h1F5, 0, 0, "R3 overlap low");
    do_req(0, 'h1F9, 0, 0, "R3 overlap high");
    load_base(2, 'h170);
    // R11 absent drives
    drv_present = 4'b0101;
    do_req(0, 'h1F0, 2, 0, "R11 absent read");
    do_req(1, 'h1F7, 0, 32'h22, "R11 absent write");
    drv_present = 4'hF;

    for (int n = 0; n < 400; n++) begin
      int w, a;
      logic [1:0] sz;
      w = $urandom % 6;
      if (w == 5) a = 'h0100 + ($urandom % 'h40);
      else a = bases[w] + ($urandom % wsize(w));
      sz = ($urandom % 8 == 0) ? 2'd3 : 2'($urandom % 3);
      io_en = ($urandom % 12 != 0);
      if ($urandom % 10 == 0) drv_present = 4'($urandom);
      do_req($urandom % 2 == 0, a, sz, $urandom, "random");
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule